// File: doc/BRIEF.md
# Per-Bank Refresh Scheduler

This block decides when each bank of one memory rank gets its per-bank refresh. It raises a request carrying a command (refresh of one bank, or precharge of one bank ahead of that refresh) and the bank and bank-group address. The request is held until a timing checker grants it. A command feedback port then reports each issued command with its bank index, and the scheduler advances its state from that report.

Time is counted in strobes of `tick_i`. A refresh falls due once per `INTERVAL_TICKS` strobes. Banks not yet refreshed in the current round form a remaining set, and the scheduler prefers an idle bank from that set. If every remaining bank is busy, it may postpone the refresh by one interval. After a refresh it may pull further refreshes in while idle banks remain. A signed flexibility counter bounds how far postponing and pulling in can go. Both bounds scale with the bank count. Once the postpone bound is reached the refresh is forced: the chosen bank is blocked from normal traffic until it has been refreshed.

The bank bit vectors use bit i for bank i. On both `req_cmd_o` and `fb_cmd_i`, 0 means precharge one bank and 1 means refresh one bank.

Top module: `pbr_refresh_sched`

## Requirements
- R1: After reset `req_valid_o` is low and `bank_block_o` is all zero. No request appears before `INTERVAL_TICKS` tick strobes have elapsed.
- R2: When a refresh falls due, the target is the lowest-numbered bank that is both in the remaining set and not busy. `req_group_o` equals the bank index divided by `BANKS_PER_GROUP`.
- R3: A bank leaves the remaining set when refresh feedback for it arrives. When the set would become empty it is refilled with all banks, so no bank is chosen twice before every bank has been refreshed once.
- R4: A forced refresh with no idle bank in the remaining set targets the lowest-numbered remaining bank, even though it is busy.
- R5: If every remaining bank is busy and the flexibility counter is below the postpone limit, no request is raised. The counter increments and the next due point moves one interval later.
- R6: A forced refresh sets the block bit of the chosen bank only. That bit clears when refresh feedback for that bank arrives.
- R7: If the chosen bank is activated, a precharge to it is requested first. After its matching feedback the bank is blocked and a refresh of that same bank is requested.
- R8: The postpone limit is `MAX_POSTPONE*NUM_BANKS` and the pull-in limit is `-(MAX_PULLIN*NUM_BANKS)`. Each limit is zero when its enable parameter is 0.
- R9: After a refresh, further idle remaining banks are refreshed at once. Each pulled-in refresh decrements the counter, and pulling in stops when the counter reaches the pull-in limit.
- R10: A request stays valid with a stable command and bank until `grant_i`. It is withdrawn in the cycle after the grant.
- R11: Feedback is ignored if it is a precharge to another bank, or a precharge while the pending request is a refresh. Such feedback leaves the request unchanged.
- R12: While pulling in, if every remaining bank is busy, the scheduler returns to regular operation and raises no request until the next due point.
- R13: If refresh feedback arrives so late that `REFB_TICKS` reaches past the following due point, the scheduler returns to regular operation and waits for that due point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Timebase strobe, one per tick |
| bank_busy_i | input | NUM_BANKS | Bank has pending traffic |
| bank_active_i | input | NUM_BANKS | Bank has an open row |
| grant_i | input | 1 | Checker accepts the current request |
| fb_valid_i | input | 1 | An issued command is being reported |
| fb_cmd_i | input | 1 | Reported command: 0 precharge, 1 refresh |
| fb_bank_i | input | log2(NUM_BANKS) | Bank of the reported command |
| req_valid_o | output | 1 | Request pending |
| req_cmd_o | output | 1 | Requested command: 0 precharge, 1 refresh |
| req_bank_o | output | log2(NUM_BANKS) | Target bank |
| req_group_o | output | log2(NUM_BANKS/BANKS_PER_GROUP) | Target bank group |
| bank_block_o | output | NUM_BANKS | Banks held off from normal traffic |

## Verification
A corrupted remaining set shows up in the next request as a repeated or skipped bank index. A wrong flexibility count shifts the first forced request by a whole interval, or lengthens or shortens a pull-in burst by a refresh. Both are visible on `req_bank_o` and on the timing of `req_valid_o` within one interval. A wrong decision after late or foreign feedback shows within a few cycles, as a request that should or should not be there. A lost block bit shows on `bank_block_o` as soon as the refresh is requested.

// File: rtl/pbr_pkg.sv
`timescale 1ns/1ps
package pbr_pkg;
  typedef enum logic {
    CMD_PRE  = 1'b0,
    CMD_REFB = 1'b1
  } pbr_cmd_e;

  typedef enum logic [1:0] {
    ST_REGULAR    = 2'd0,
    ST_PRECHARGED = 2'd1,
    ST_PULLEDIN   = 2'd2
  } pbr_state_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_REQ  = 2'd1,
    PH_WAIT = 2'd2
  } pbr_phase_e;
endpackage

// File: rtl/pbr_first_set.sv
`timescale 1ns/1ps
// Priority encoder: lowest set bit wins.
module pbr_first_set #(
  parameter int W  = 8,
  parameter int IW = 3
) (
  input  logic [W-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = |vec_i;
    idx_o   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/pbr_remaining_set.sv
`timescale 1ns/1ps
// Banks not yet refreshed in the current round; refills when emptied.
module pbr_remaining_set #(
  parameter int NB = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          remove_i,
  input  logic [IW-1:0] idx_i,
  output logic [NB-1:0] mask_o
);
  logic [NB-1:0] hit;
  logic [NB-1:0] after;

  always_comb begin
    hit        = '0;
    hit[idx_i] = 1'b1;
    after      = mask_o & ~hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_o <= '1;
    end else if (remove_i) begin
      mask_o <= (after == '0) ? '1 : after;
    end
  end
endmodule

// File: rtl/pbr_flex_timer.sv
`timescale 1ns/1ps
// Due-point countdown in ticks plus the signed flexibility counter.
module pbr_flex_timer #(
  parameter int INTERVAL = 390,
  parameter int TW       = 12,
  parameter int CW       = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick_i,
  input  logic                 advance_i,
  input  logic                 inc_i,
  input  logic                 dec_i,
  output logic signed [TW-1:0] left_o,
  output logic                 due_o,
  output logic signed [CW-1:0] cnt_o
);
  localparam logic signed [TW-1:0] INT_S = TW'(INTERVAL);
  localparam logic signed [TW-1:0] MIN_S = {1'b1, {(TW-1){1'b0}}};

  logic signed [TW-1:0] step;
  logic signed [TW-1:0] add;
  logic signed [TW-1:0] left_n;

  always_comb begin
    step   = (tick_i && (left_o != MIN_S)) ? TW'(1) : '0;
    add    = advance_i ? INT_S : '0;
    left_n = left_o - step + add;
    due_o  = left_o[TW-1] || (left_o == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      left_o <= INT_S;
      cnt_o  <= '0;
    end else begin
      left_o <= left_n;
      if (inc_i) begin
        cnt_o <= cnt_o + CW'(1);
      end else if (dec_i) begin
        cnt_o <= cnt_o - CW'(1);
      end
    end
  end
endmodule

// File: rtl/pbr_refresh_sched.sv
`timescale 1ns/1ps
module pbr_refresh_sched
  import pbr_pkg::*;
#(
  parameter int NUM_BANKS       = 8,
  parameter int BANKS_PER_GROUP = 4,
  parameter int INTERVAL_TICKS  = 390,
  parameter int REFB_TICKS      = 90,
  parameter int PRE_TICKS       = 8,
  parameter bit POSTPONE_EN     = 1'b1,
  parameter int MAX_POSTPONE    = 8,
  parameter bit PULLIN_EN       = 1'b1,
  parameter int MAX_PULLIN      = 8,
  localparam int BW  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int NG  = NUM_BANKS / BANKS_PER_GROUP,
  localparam int GW  = (NG > 1) ? $clog2(NG) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick_i,
  input  logic [NUM_BANKS-1:0] bank_busy_i,
  input  logic [NUM_BANKS-1:0] bank_active_i,
  input  logic                 grant_i,
  input  logic                 fb_valid_i,
  input  logic                 fb_cmd_i,
  input  logic [BW-1:0]        fb_bank_i,
  output logic                 req_valid_o,
  output logic                 req_cmd_o,
  output logic [BW-1:0]        req_bank_o,
  output logic [GW-1:0]        req_group_o,
  output logic [NUM_BANKS-1:0] bank_block_o
);
  localparam int POST_LIM = POSTPONE_EN ? MAX_POSTPONE * NUM_BANKS : 0;
  localparam int PULL_LIM = PULLIN_EN ? -(MAX_PULLIN * NUM_BANKS) : 0;
  localparam int CW = $clog2(MAX_POSTPONE * NUM_BANKS + MAX_PULLIN * NUM_BANKS + 2) + 2;
  localparam int TW = $clog2(INTERVAL_TICKS + REFB_TICKS + PRE_TICKS + 2) + 3;
  localparam logic signed [CW-1:0] POST_S = CW'(POST_LIM);
  localparam logic signed [CW-1:0] PULL_S = CW'(PULL_LIM);
  localparam logic signed [TW-1:0] INT_S  = TW'(INTERVAL_TICKS);
  localparam logic signed [TW-1:0] REFB_S = TW'(REFB_TICKS);
  localparam logic signed [TW-1:0] PRE_S  = TW'(PRE_TICKS);

  function automatic logic [GW-1:0] group_of(input logic [BW-1:0] b);
    return GW'(int'(b) / BANKS_PER_GROUP);
  endfunction

  // state
  pbr_state_e           st_q, st_n;
  pbr_phase_e           ph_q, ph_n;
  pbr_cmd_e             pend_q, pend_n;
  logic [BW-1:0]        cur_q, cur_n;
  logic [GW-1:0]        grp_q, grp_n;
  logic [NUM_BANKS-1:0] blk_q, blk_n;
  logic                 rv_q, rv_n;

  // helpers
  logic [NUM_BANKS-1:0] remain_q;
  logic [NUM_BANKS-1:0] idle_rem;
  logic                 idle_found, rem_found;
  logic [BW-1:0]        idle_idx, rem_idx, sel_idx;
  logic signed [TW-1:0] left;
  logic                 due;
  logic signed [CW-1:0] flex_cnt;
  logic signed [CW-1:0] cnt_after;
  logic                 adv, inc, dec, rm;
  logic                 forced, late_refb, late_pre;
  logic                 refb_hit, pre_hit;

  assign idle_rem = remain_q & ~bank_busy_i;

  pbr_first_set #(.W(NUM_BANKS), .IW(BW)) u_pick_idle (
    .vec_i  (idle_rem),
    .found_o(idle_found),
    .idx_o  (idle_idx)
  );

  pbr_first_set #(.W(NUM_BANKS), .IW(BW)) u_pick_rem (
    .vec_i  (remain_q),
    .found_o(rem_found),
    .idx_o  (rem_idx)
  );

  pbr_remaining_set #(.NB(NUM_BANKS), .IW(BW)) u_remain (
    .clk     (clk),
    .rst     (rst),
    .remove_i(rm),
    .idx_i   (cur_q),
    .mask_o  (remain_q)
  );

  pbr_flex_timer #(.INTERVAL(INTERVAL_TICKS), .TW(TW), .CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .tick_i   (tick_i),
    .advance_i(adv),
    .inc_i    (inc),
    .dec_i    (dec),
    .left_o   (left),
    .due_o    (due),
    .cnt_o    (flex_cnt)
  );

  always_comb begin
    sel_idx   = (idle_found || !rem_found) ? idle_idx : rem_idx;
    forced    = (flex_cnt == POST_S);
    late_refb = (REFB_S >= (left + INT_S));
    late_pre  = (PRE_S >= (left + INT_S));
    refb_hit  = fb_valid_i && (fb_cmd_i == CMD_REFB) && (ph_q == PH_WAIT) &&
                (pend_q == CMD_REFB) && (fb_bank_i == cur_q);
    pre_hit   = fb_valid_i && (fb_cmd_i == CMD_PRE) && (ph_q != PH_IDLE) &&
                (pend_q == CMD_PRE) && (fb_bank_i == cur_q);
  end

  always_comb begin
    st_n      = st_q;
    ph_n      = ph_q;
    pend_n    = pend_q;
    cur_n     = cur_q;
    grp_n     = grp_q;
    blk_n     = blk_q;
    rv_n      = rv_q;
    adv       = 1'b0;
    inc       = 1'b0;
    dec       = 1'b0;
    rm        = 1'b0;
    cnt_after = flex_cnt;

    if (pre_hit) begin
      // precharge ahead of refresh has gone out
      ph_n = PH_IDLE;
      rv_n = 1'b0;
      if (late_pre) begin
        st_n = ST_REGULAR;
        adv  = 1'b1;
      end else begin
        blk_n[cur_q] = 1'b1;
        st_n         = ST_PRECHARGED;
      end
    end else if (refb_hit) begin
      ph_n         = PH_IDLE;
      rm           = 1'b1;
      blk_n[cur_q] = 1'b0;
      if (st_q == ST_PULLEDIN) begin
        dec       = 1'b1;
        cnt_after = flex_cnt - CW'(1);
      end else begin
        st_n = ST_PULLEDIN;
      end
      if ((cnt_after == PULL_S) || late_refb) begin
        st_n = ST_REGULAR;
        adv  = 1'b1;
      end
    end else if (ph_q == PH_REQ) begin
      if (grant_i) begin
        ph_n = PH_WAIT;
        rv_n = 1'b0;
      end
    end else if (ph_q == PH_IDLE) begin
      unique case (st_q)
        ST_REGULAR: begin
          if (due) begin
            if (!idle_found && !forced) begin
              inc = 1'b1;
              adv = 1'b1;
            end else begin
              cur_n = sel_idx;
              grp_n = group_of(sel_idx);
              ph_n  = PH_REQ;
              rv_n  = 1'b1;
              if (forced) blk_n[sel_idx] = 1'b1;
              if (bank_active_i[sel_idx]) begin
                pend_n = CMD_PRE;
              end else begin
                pend_n = CMD_REFB;
                if (forced) st_n = ST_PRECHARGED;
              end
            end
          end
        end
        ST_PULLEDIN: begin
          if (!idle_found) begin
            st_n = ST_REGULAR;
            adv  = 1'b1;
          end else begin
            cur_n  = idle_idx;
            grp_n  = group_of(idle_idx);
            ph_n   = PH_REQ;
            rv_n   = 1'b1;
            pend_n = bank_active_i[idle_idx] ? CMD_PRE : CMD_REFB;
          end
        end
        ST_PRECHARGED: begin
          ph_n   = PH_REQ;
          rv_n   = 1'b1;
          pend_n = CMD_REFB;
        end
        default: st_n = ST_REGULAR;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_REGULAR;
      ph_q   <= PH_IDLE;
      pend_q <= CMD_REFB;
      cur_q  <= '0;
      grp_q  <= '0;
      blk_q  <= '0;
      rv_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      ph_q   <= ph_n;
      pend_q <= pend_n;
      cur_q  <= cur_n;
      grp_q  <= grp_n;
      blk_q  <= blk_n;
      rv_q   <= rv_n;
    end
  end

  assign req_valid_o  = rv_q;
  assign req_cmd_o    = pend_q;
  assign req_bank_o   = cur_q;
  assign req_group_o  = grp_q;
  assign bank_block_o = blk_q;
endmodule

// File: rtl/pbr_refresh_sched_chk.sv
`timescale 1ns/1ps
module pbr_refresh_sched_chk #(
  parameter int NUM_BANKS = 8,
  parameter int BW        = 3,
  parameter int CW        = 8,
  parameter int POST_LIM  = 64,
  parameter int PULL_LIM  = -64
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 grant_i,
  input logic                 fb_valid_i,
  input logic                 fb_cmd_i,
  input logic                 req_valid_o,
  input logic                 req_cmd_o,
  input logic [BW-1:0]        req_bank_o,
  input logic [NUM_BANKS-1:0] bank_block_o,
  input logic [NUM_BANKS-1:0] remain,
  input logic signed [CW-1:0] cnt
);
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid_o && !grant_i && !(fb_valid_i && (fb_cmd_i == 1'b0)))
      |=> (req_valid_o && $stable(req_bank_o) && $stable(req_cmd_o)));

  // R10
  grant_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid_o && grant_i) |=> !req_valid_o);

  // R3
  remain_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    remain != '0);

  // R6
  block_single_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(bank_block_o & ~$past(bank_block_o)) <= 1);

  // R8
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt <= POST_LIM) && (cnt >= PULL_LIM));
endmodule

bind pbr_refresh_sched pbr_refresh_sched_chk #(
  .NUM_BANKS(NUM_BANKS),
  .BW       (BW),
  .CW       (CW),
  .POST_LIM (POST_LIM),
  .PULL_LIM (PULL_LIM)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .grant_i     (grant_i),
  .fb_valid_i  (fb_valid_i),
  .fb_cmd_i    (fb_cmd_i),
  .req_valid_o (req_valid_o),
  .req_cmd_o   (req_cmd_o),
  .req_bank_o  (req_bank_o),
  .bank_block_o(bank_block_o),
  .remain      (remain_q),
  .cnt         (flex_cnt)
);

// File: tb/pbr_refresh_sched_tb.sv
`timescale 1ns/1ps
module pbr_refresh_sched_tb;
  localparam int NB  = 4;
  localparam int BPG = 2;
  localparam int IV  = 40;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick = 1'b0;
  logic [NB-1:0] busy = '0;
  logic [NB-1:0] act = '0;
  logic          grant = 1'b0;
  logic          fb_valid = 1'b0;
  logic          fb_cmd = 1'b0;
  logic [1:0]    fb_bank = '0;
  logic          req_valid;
  logic          req_cmd;
  logic [1:0]    req_bank;
  logic          req_group;
  logic [NB-1:0] block;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  pbr_refresh_sched #(
    .NUM_BANKS(NB), .BANKS_PER_GROUP(BPG), .INTERVAL_TICKS(IV),
    .REFB_TICKS(3), .PRE_TICKS(1), .POSTPONE_EN(1'b1), .MAX_POSTPONE(1),
    .PULLIN_EN(1'b1), .MAX_PULLIN(1)
  ) u_dut (
    .clk(clk), .rst(rst), .tick_i(tick), .bank_busy_i(busy),
    .bank_active_i(act), .grant_i(grant), .fb_valid_i(fb_valid),
    .fb_cmd_i(fb_cmd), .fb_bank_i(fb_bank), .req_valid_o(req_valid),
    .req_cmd_o(req_cmd), .req_bank_o(req_bank), .req_group_o(req_group),
    .bank_block_o(block)
  );

  typedef struct packed {
    logic [3:0] busy;
    logic [3:0] act;
    logic       cmd;
    logic [1:0] bank;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{4'b0000, 4'b0000, 1'b1, 2'd0},
    '{4'b0001, 4'b0000, 1'b1, 2'd1},
    '{4'b0011, 4'b0100, 1'b0, 2'd2},
    '{4'b0111, 4'b0000, 1'b1, 2'd3},
    '{4'b1010, 4'b0001, 1'b0, 2'd0},
    '{4'b1101, 4'b0010, 1'b0, 2'd1}
  };

  task automatic chk(input string tag, input string what, input int actual, input int expect_v);
    n_chk++;
    if (actual != expect_v) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, actual, expect_v);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; tick = 1'b0; busy = '0; act = '0;
    grant = 1'b0; fb_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_req(input int limit, output int got);
    got = 0;
    tick = 1'b1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (req_valid) begin
        got = 1;
        break;
      end
    end
    tick = 1'b0;
  endtask

  task automatic quiet(input int n, output int seen);
    seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (req_valid) seen = 1;
    end
  endtask

  task automatic send_fb(input logic c, input logic [1:0] b);
    fb_valid = 1'b1; fb_cmd = c; fb_bank = b;
    @(negedge clk);
    fb_valid = 1'b0;
  endtask

  task automatic serve(input string tag);
    logic       c;
    logic [1:0] b;
    c = req_cmd; b = req_bank;
    grant = 1'b1;
    @(negedge clk);
    grant = 1'b0;
    chk(tag, "request withdrawn after grant", int'(req_valid), 0);
    send_fb(c, b);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    int got;
    int seen;
    int first;

    // R1 reset state
    do_reset();
    chk("R1", "req_valid after reset", int'(req_valid), 0);
    chk("R1", "block after reset", int'(block), 0);
    tick = 1'b1;
    quiet(35, seen);
    chk("R1", "request before first interval", seen, 0);

    // R2 / R7 selection table
    foreach (VECS[k]) begin
      do_reset();
      busy = VECS[k].busy;
      act  = VECS[k].act;
      wait_req(60, got);
      chk("R2", "request raised", got, 1);
      chk("R7", "command", int'(req_cmd), int'(VECS[k].cmd));
      chk("R2", "bank", int'(req_bank), int'(VECS[k].bank));
      chk("R2", "group", int'(req_group), int'(VECS[k].bank) / BPG);
    end

    // R10, R11, R9, R3: pull-in burst with all banks idle
    do_reset();
    wait_req(60, got);
    chk("R2", "first bank", int'(req_bank), 0);
    repeat (3) @(negedge clk);
    chk("R10", "held without grant", int'(req_valid), 1);
    chk("R10", "bank stable", int'(req_bank), 0);
    send_fb(1'b0, 2'd0);
    chk("R11", "precharge feedback during refresh request", int'(req_valid), 1);
    chk("R11", "command kept", int'(req_cmd), 1);
    serve("R10");
    for (int k = 1; k <= 4; k++) begin
      wait_req(10, got);
      chk("R9", "pulled-in request", got, 1);
      chk("R3", "pulled-in bank", int'(req_bank), k % NB);
      serve("R9");
    end
    quiet(20, seen);
    chk("R8", "pull-in stops at limit", seen, 0);
    wait_req(60, got);
    chk("R3", "next round request", got, 1);
    chk("R3", "refreshed bank skipped", int'(req_bank), 1);
    serve("R3");
    quiet(20, seen);
    chk("R9", "no pull-in at limit", seen, 0);

    // R5, R8, R4, R6: postpone then forced refresh
    do_reset();
    busy = '1;
    tick = 1'b1;
    first = 0;
    for (int i = 1; i <= 400; i++) begin
      @(negedge clk);
      if (req_valid) begin
        first = i;
        break;
      end
    end
    tick = 1'b0;
    chk("R5", "no request while postponing", int'(first >= 195), 1);
    chk("R8", "forced after limit intervals", int'(first <= 210 && first > 0), 1);
    chk("R4", "forced command", int'(req_cmd), 1);
    chk("R4", "forced bank", int'(req_bank), 0);
    chk("R6", "block vector", int'(block), 1);
    serve("R6");
    chk("R6", "block cleared", int'(block), 0);
    quiet(20, seen);
    chk("R12", "busy banks after forced", seen, 0);

    // R7, R11: precharge first
    do_reset();
    busy = 4'b1110;
    act  = 4'b0001;
    wait_req(60, got);
    chk("R7", "precharge command", int'(req_cmd), 0);
    chk("R7", "precharge bank", int'(req_bank), 0);
    send_fb(1'b0, 2'd1);
    chk("R11", "foreign precharge ignored", int'(req_valid), 1);
    chk("R11", "bank kept", int'(req_bank), 0);
    serve("R7");
    act = '0;
    wait_req(10, got);
    chk("R7", "refresh after precharge", int'(req_cmd), 1);
    chk("R7", "same bank", int'(req_bank), 0);
    chk("R7", "bank blocked", int'(block), 1);
    serve("R7");

    // R12: pulled-in with all remaining busy
    do_reset();
    wait_req(60, got);
    busy = 4'b1110;
    serve("R12");
    quiet(20, seen);
    chk("R12", "no request", seen, 0);

    // R13: late refresh feedback
    do_reset();
    wait_req(60, got);
    grant = 1'b1;
    @(negedge clk);
    grant = 1'b0;
    tick = 1'b1;
    repeat (37) @(negedge clk);
    tick = 1'b0;
    send_fb(1'b1, 2'd0);
    quiet(20, seen);
    chk("R13", "no pull-in after late refresh", seen, 0);
    wait_req(10, got);
    chk("R13", "resumes at due point", got, 1);
    chk("R13", "next bank", int'(req_bank), 1);

    finish_run();
  end
endmodule